// File: doc/BRIEF.md
# Single-Wire Bus Slave Addressing and Reply Timing

This block decides whether a slave on a shared single-wire serial bus should answer a request and when it may begin its answer. It holds a programmable node address. A chain-select input adds one to that address, with a ceiling, so that identical devices wired in a daisy chain can each take a distinct address. When a request ends, the destination field of the request is compared against the effective address. On a match, a turnaround timer counts bit-time ticks and then raises a one-cycle reply permit. The wait is an odd multiple of eight bit times, selected by a 4-bit code whose values are decoded in pairs.

A separate polarity bit drives a static chain output. That output can feed the chain-select input of the next device. The bit resets to 1, so a chain is usable straight out of reset.

Two things are handled elsewhere: serial framing and checksums belong to the surrounding UART, and register contents other than the three configuration fields here belong to the rest of the device. A turnaround code of 0 or 1 gives the shortest wait. That shortest wait must not be used when more than one slave shares the line.

Top module: `swb_slave_addr`

## Requirements
- R1: After reset the node address is 0, the turnaround code is 0, the chain output is 1, the reply permit is 0 and the effective address is 0.
- R2: The configuration port takes one write per clock with `cfg_we` high, decoded by `cfg_sel`:
  - 0 loads the node address from `cfg_wdata[7:0]`.
  - 1 loads the turnaround code from `cfg_wdata[3:0]`.
  - 2 loads the chain polarity from `cfg_wdata[0]`.
  - 3 changes nothing.
  - Each change is visible on the outputs in the cycle after the write edge.
- R3: With `next_sel` low the effective address equals the node address. With `next_sel` high and a node address of 253 or less, it equals the node address plus one.
- R4: With `next_sel` high and a node address of 254 or more, the effective address is 254. While `next_sel` is high, the effective address never exceeds 254.
- R5: A `req_end` pulse whose `req_dest` equals the effective address starts the timer. The wait is 8 × (2 × floor(code/2) + 1) bit-time ticks, so it runs from 8 ticks for codes 0 and 1 up to 120 ticks for codes 14 and 15.
- R6: The reply permit rises in the cycle after the clock edge that samples the last counted tick. It stays high for exactly one cycle.
- R7: A `req_end` whose `req_dest` differs from the effective address does not start the timer and never produces a reply permit.
- R8: A `req_start` pulse while the timer runs cancels it; no reply permit follows for that request.
- R9: Address and code writes made while the timer runs do not change the wait in progress. They apply from the next request.
- R10: `chain_out` equals the last written polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Field select: 0 address, 1 turnaround code, 2 polarity, 3 none |
| cfg_wdata | input | 8 | Configuration write data |
| next_sel | input | 1 | Chain-select input, high adds one to the address |
| req_start | input | 1 | One-cycle pulse: a new request begins on the line |
| req_end | input | 1 | One-cycle pulse: request complete, `req_dest` valid |
| req_dest | input | 8 | Destination address carried by the request |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| eff_addr | output | 8 | Effective node address |
| reply_ok | output | 1 | One-cycle reply permit |
| chain_out | output | 1 | Chain output level, set by the polarity bit |

## Verification
The bench builds the block with its default parameters: an 8-bit address with a ceiling of 254, a 4-bit turnaround code and eight ticks per step. With these values, both the ceiling cases (253, 254 and 255 with chain-select high) and the longest 120-tick wait can be reached within a short run. Under the same build the bench also covers a cancellation partway through a count and a reconfiguration during a count.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [1:0] {
    SEL_NODE  = 2'd0,
    SEL_DELAY = 2'd1,
    SEL_POL   = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/swb_cfg_regs.sv
module swb_cfg_regs
  import swb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  cfg_sel_e          cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] node_addr,
  output logic [CODE_W-1:0] delay_code,
  output logic              chain_pol
);
  logic [ADDR_W-1:0] node_d;
  logic [CODE_W-1:0] code_d;
  logic              pol_d;

  always_comb begin
    node_d = node_addr;
    code_d = delay_code;
    pol_d  = chain_pol;
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_NODE:  node_d = cfg_wdata;
        SEL_DELAY: code_d = cfg_wdata[CODE_W-1:0];
        SEL_POL:   pol_d  = cfg_wdata[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_addr  <= '0;
      delay_code <= '0;
      chain_pol  <= 1'b1;
    end else begin
      node_addr  <= node_d;
      delay_code <= code_d;
      chain_pol  <= pol_d;
    end
  end

  // R10: polarity write lands one cycle later
  a_r10_pol_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_POL) |=> (chain_pol == $past(cfg_wdata[0])));
endmodule

// File: rtl/swb_addr_match.sv
module swb_addr_match #(
  parameter int ADDR_W    = 8,
  parameter int ADDR_CEIL = 254
) (
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              next_sel,
  input  logic [ADDR_W-1:0] req_dest,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] CEIL = ADDR_W'(ADDR_CEIL);

  always_comb begin
    if (!next_sel)              eff_addr = node_addr;
    else if (node_addr >= CEIL) eff_addr = CEIL;
    else                        eff_addr = node_addr + 1'b1;
    hit = (req_dest == eff_addr);
  end
endmodule

// File: rtl/swb_reply_timer.sv
module swb_reply_timer #(
  parameter int CODE_W   = 4,
  parameter int BIT_MULT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              abort,
  input  logic              bit_tick,
  input  logic [CODE_W-1:0] delay_code,
  output logic              busy,
  output logic              reply_ok
);
  localparam int CNT_W = $clog2(BIT_MULT * (1 << CODE_W));

  logic [CNT_W-1:0]  cnt_q, cnt_d, tgt_q, tgt_d, tgt_new;
  logic [CODE_W-1:0] odd_mult;
  logic              busy_d, ok_d;

  assign odd_mult = {delay_code[CODE_W-1:1], 1'b1};
  assign tgt_new  = CNT_W'(odd_mult) * CNT_W'(BIT_MULT);

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt_q;
    tgt_d  = tgt_q;
    ok_d   = 1'b0;
    if (arm) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      tgt_d  = tgt_new;
    end else if (abort) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy && bit_tick) begin
      if (cnt_q + 1'b1 == tgt_q) begin
        busy_d = 1'b0;
        cnt_d  = '0;
        ok_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      tgt_q    <= '0;
      reply_ok <= 1'b0;
    end else begin
      busy     <= busy_d;
      cnt_q    <= cnt_d;
      tgt_q    <= tgt_d;
      reply_ok <= ok_d;
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reply_ok |=> !reply_ok);
  a_r6_from_count: assert property (@(posedge clk) disable iff (!rst_n)
    reply_ok |-> $past(busy));
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !arm) |=> (!busy && !reply_ok));
endmodule

// File: rtl/swb_slave_addr.sv
module swb_slave_addr
  import swb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CODE_W    = 4,
  parameter int BIT_MULT  = 8,
  parameter int ADDR_CEIL = 254
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              next_sel,
  input  logic              req_start,
  input  logic              req_end,
  input  logic [ADDR_W-1:0] req_dest,
  input  logic              bit_tick,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              reply_ok,
  output logic              chain_out
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [ADDR_W-1:0] node_addr;
  logic [CODE_W-1:0] delay_code;
  logic              hit, busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  swb_cfg_regs #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel_e'(cfg_sel)), .cfg_wdata(cfg_wdata),
    .node_addr(node_addr), .delay_code(delay_code), .chain_pol(chain_out)
  );

  swb_addr_match #(.ADDR_W(ADDR_W), .ADDR_CEIL(ADDR_CEIL)) u_match (
    .node_addr(node_addr), .next_sel(next_sel), .req_dest(req_dest),
    .eff_addr(eff_addr), .hit(hit)
  );

  swb_reply_timer #(.CODE_W(CODE_W), .BIT_MULT(BIT_MULT)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .arm(req_end && hit), .abort(req_start),
    .bit_tick(bit_tick), .delay_code(delay_code),
    .busy(busy), .reply_ok(reply_ok)
  );

  a_r4_ceiling: assert property (@(posedge clk) disable iff (!rst_int_n)
    next_sel |-> (eff_addr <= ADDR_W'(ADDR_CEIL)));
  a_r7_no_start_on_miss: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_end && !hit && !busy && !req_start) |=> !busy);
endmodule

// File: tb/test_swb_slave_addr.sv
module test_swb_slave_addr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       next_sel = 1'b0;
  logic       req_start = 1'b0;
  logic       req_end = 1'b0;
  logic [7:0] req_dest = 8'd0;
  logic       bit_tick = 1'b0;
  logic [7:0] eff_addr;
  logic       reply_ok;
  logic       chain_out;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  swb_slave_addr i_swb_slave_addr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .next_sel(next_sel), .req_start(req_start),
    .req_end(req_end), .req_dest(req_dest), .bit_tick(bit_tick),
    .eff_addr(eff_addr), .reply_ok(reply_ok), .chain_out(chain_out)
  );

  localparam int NV = 8;
  localparam logic [7:0] V_NODE [NV] = '{8'd5, 8'd5, 8'd5, 8'd100, 8'd253, 8'd254, 8'd0, 8'd42};
  localparam logic       V_NSEL [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [3:0] V_CODE [NV] = '{4'd0, 4'd3, 4'd2, 4'd5, 4'd7, 4'd9, 4'd15, 4'd12};
  localparam logic [7:0] V_DEST [NV] = '{8'd5, 8'd6, 8'd5, 8'd100, 8'd254, 8'd254, 8'd0, 8'd43};
  localparam logic [7:0] V_EFF  [NV] = '{8'd5, 8'd6, 8'd6, 8'd100, 8'd254, 8'd254, 8'd0, 8'd42};
  localparam int         V_TICK [NV] = '{8, 24, 0, 40, 56, 72, 120, 0};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send_req(input logic [7:0] dest);
    @(negedge clk); req_end = 1'b1; req_dest = dest;
    @(negedge clk); req_end = 1'b0;
  endtask

  // returns tick index at which reply_ok appeared, 0 if none within maxn
  task automatic tick_until(input int maxn, output int got);
    got = 0;
    for (int i = 1; i <= maxn; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
      if (reply_ok) begin
        got = i;
        @(negedge clk);
        chk(!reply_ok, "R6 pulse width", int'(reply_ok), 0);
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(eff_addr == 8'd0, "R1 eff_addr", eff_addr, 0);
    chk(chain_out == 1'b1, "R1 chain_out", chain_out, 1);
    chk(reply_ok == 1'b0, "R1 reply_ok", reply_ok, 0);
    send_req(8'd0);
    tick_until(20, got);
    chk(got == 8, "R1 R5 default code wait", got, 8);

    // vector table: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      cfg_write(2'd0, V_NODE[v]);
      cfg_write(2'd1, {4'd0, V_CODE[v]});
      @(negedge clk); next_sel = V_NSEL[v];
      @(negedge clk);
      chk(eff_addr == V_EFF[v], "R3 R4 eff_addr", eff_addr, V_EFF[v]);
      send_req(V_DEST[v]);
      tick_until(130, got);
      chk(got == V_TICK[v], "R5 R7 reply tick", got, V_TICK[v]);
    end

    // R4 out-of-range node with chain select
    cfg_write(2'd0, 8'd255);
    next_sel = 1'b1;
    @(negedge clk);
    chk(eff_addr == 8'd254, "R4 node 255 ceiling", eff_addr, 254);
    next_sel = 1'b0;
    @(negedge clk);
    chk(eff_addr == 8'd255, "R3 node 255 plain", eff_addr, 255);

    // R8 abort during count
    cfg_write(2'd0, 8'd17);
    cfg_write(2'd1, 8'd2);
    send_req(8'd17);
    tick_until(10, got);
    chk(got == 0, "R8 before abort", got, 0);
    @(negedge clk); req_start = 1'b1;
    @(negedge clk); req_start = 1'b0;
    tick_until(40, got);
    chk(got == 0, "R8 after abort", got, 0);

    // R9 reconfigure mid-count
    cfg_write(2'd0, 8'd9);
    cfg_write(2'd1, 8'd1);
    send_req(8'd9);
    tick_until(3, got);
    chk(got == 0, "R9 early ticks", got, 0);
    cfg_write(2'd0, 8'd20);
    cfg_write(2'd1, 8'd15);
    tick_until(130, got);
    chk(got == 5, "R9 wait unchanged", got, 5);
    chk(eff_addr == 8'd20, "R9 new address", eff_addr, 20);
    send_req(8'd20);
    tick_until(130, got);
    chk(got == 120, "R9 next request uses new code", got, 120);

    // R10 polarity, R2 select 3 has no effect
    cfg_write(2'd2, 8'd0);
    chk(chain_out == 1'b0, "R10 polarity 0", chain_out, 0);
    cfg_write(2'd3, 8'hFF);
    chk(chain_out == 1'b0, "R2 sel3 polarity", chain_out, 0);
    chk(eff_addr == 8'd20, "R2 sel3 address", eff_addr, 20);
    send_req(8'd20);
    tick_until(130, got);
    chk(got == 120, "R2 sel3 code", got, 120);
    cfg_write(2'd2, 8'd1);
    chk(chain_out == 1'b1, "R10 polarity 1", chain_out, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule